// File: doc/BRIEF.md
# Timebase Load Sequencing Controller

This block is the time facility controller of one hardware thread. It keeps a timebase counter and a single mode/status word. Software uses the word in two phases. First it asks the controller to get ready for a new timebase value. Then it asks the controller to take the chip time-of-day value at the next sync boundary. The controller walks a fixed sequence of states: reset, not-set, sync-wait, get-value and running. It clears each request bit itself once the matching step is done, so software only has to poll the word.

The controller reaches the running state only when three things happen in this order: the move request, a sync boundary, and a time-of-day transfer. Once it is running, the timebase advances by one on each step pulse. A programmable window limits how long the controller waits for the sync boundary and for the transfer; if a wait runs past it, the controller falls back to not-set and raises a timeout flag. A sticky error flag records a step-error input, or a gap between step pulses that grows longer than the programmed limit.

Bit numbers below count from the least significant bit, which is bit 0.

Top module: `timebase_loader`

## Requirements
- R1: A synchronous active-low reset sets the state to RESET, clears every bit of the mode word and clears the timebase to 0. This holds even when reset arrives in the middle of a sequence.
- R2: The 4-bit state field sits in bits 63:60 and is encoded RESET=0, NOT_SET=2, SYNC_WAIT=6, GET_TOD=7, RUNNING=8; no other value ever appears there. Bits 15:0 hold the timing configuration, and bits 7:0 of it are the step-gap limit. Bits 47:32 hold the wait limit. Both fields read back as last written. Bits that carry no field read 0, and writes to the state field are ignored.
- R3: Writing 1 to bit 16 (load request) while in RESET makes bit 16 read 1 for one cycle. On the next cycle the state becomes NOT_SET and bit 16 reads 0. Outside RESET, a 1 written to bit 16 is ignored.
- R4: Writing 1 to bit 18 (move request) while in NOT_SET sets bit 18 and enters SYNC_WAIT on that same clock edge. Outside NOT_SET the write is ignored. In SYNC_WAIT a sync pulse moves the controller to GET_TOD. Sync pulses in any other state have no effect.
- R5: In GET_TOD a transfer strobe loads tod_value into the timebase, enters RUNNING and clears bit 18, all on one edge. A strobe in any other state leaves the timebase and the state unchanged.
- R6: With a wait limit of L, the controller accepts its awaited event (a sync pulse in SYNC_WAIT, a strobe in GET_TOD) during the first L+1 cycles of that state. If the event has not arrived by then, it sets bit 54, clears bit 18 and returns to NOT_SET.
- R7: In RUNNING the timebase increases by exactly 1 on each cycle that has a step pulse, and holds otherwise.
- R8: In RUNNING, with a step-gap limit of M, bit 51 is set once M+1 consecutive cycles pass without a step pulse. The count starts at entry to RUNNING or at the last step pulse.
- R9: A step_err pulse sets bit 51 in any state. Bits 51 and 54 stay set until software writes 1 to them. A set event in the same cycle as that write wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 64 | Write data for the mode word |
| mode_rdata | output | 64 | Current mode/status word |
| sync_pulse | input | 1 | One-cycle sync-boundary pulse |
| tod_strobe | input | 1 | Time-of-day transfer strobe |
| tod_value | input | TB_W (64) | Time-of-day value carried by the strobe |
| step_pulse | input | 1 | Timebase step pulse |
| step_err | input | 1 | Step-error indication |
| tb_value | output | TB_W (64) | Current timebase |

## Verification
A table of load sequences is applied to the main function. The entries vary the wait limit and the number of idle cycles placed before the sync pulse and before the transfer strobe. The idle counts are chosen to sit exactly at the limit, one cycle past it, and at a limit of zero. This separates three outcomes: acceptance on the last allowed cycle, a timeout in SYNC_WAIT, and a timeout in GET_TOD. Directed sequences then present events out of order, such as a strobe during SYNC_WAIT, a sync pulse in NOT_SET, or requests made in the wrong state, and show at the ports that each one is ignored. Further directed sequences cover step counting and the step-gap boundary (M versus M+1 idle cycles), set-over-clear priority on the flags, and a reset taken from RUNNING.

// File: rtl/tbload_pkg.sv
// Shared constants and the state type for the timebase load controller.
// Assumes bit numbers count from the least significant bit of a 64-bit word.
package tbload_pkg;
    localparam int REG_W       = 64;
    localparam int CFG_W       = 16;
    localparam int GAP_W       = 8;
    localparam int LOAD_BIT    = 16;
    localparam int MOVE_BIT    = 18;
    localparam int LIM_LO      = 32;
    localparam int LIM_W       = 16;
    localparam int STEPERR_BIT = 51;
    localparam int TMO_BIT     = 54;
    localparam int STATE_LO    = 60;
    localparam int STATE_W     = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_RESET     = 4'd0,
        ST_NOT_SET   = 4'd2,
        ST_SYNC_WAIT = 4'd6,
        ST_GET_TOD   = 4'd7,
        ST_RUNNING   = 4'd8
    } tb_state_e;
endpackage

// File: rtl/tbload_idle_limit.sv
// Idle-window limiter: counts the cycles for which it is armed and no event
// has arrived, and raises over_o on the cycle the count reaches limit_i.
// Assumes the caller leaves the armed condition, or re-arms it, after over_o.
module tbload_idle_limit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_i,
    input  logic             event_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             over_o
);
    logic [CNT_W-1:0] cnt_q;

    // Window expires when no event arrives and the count has reached the limit.
    always_comb over_o = armed_i && !event_i && (cnt_q >= limit_i);

    // Count idle armed cycles; restart on disarm, on an event, or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed_i || event_i || over_o) cnt_q <= '0;
        else                                         cnt_q <= cnt_q + 1'b1;
    end

    // R6: count stays within the window while the limit is left unchanged
    assert_window_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && !event_i && !over_o && $stable(limit_i)) |=> (cnt_q <= limit_i));
endmodule

// File: rtl/tbload_counter.sv
// Timebase register: loads a new value or steps by one.
// Assumes load_i and inc_i are never asserted in the same cycle.
module tbload_counter #(
    parameter int TB_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [TB_W-1:0] load_val_i,
    input  logic            inc_i,
    output logic [TB_W-1:0] tb_o
);
    // Hold, load or step the timebase.
    always_ff @(posedge clk) begin
        if (!rst_n)      tb_o <= '0;
        else if (load_i) tb_o <= load_val_i;
        else if (inc_i)  tb_o <= tb_o + 1'b1;
    end

    // R5: load and step requests never overlap
    assert_no_load_step_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !inc_i);
endmodule

// File: rtl/timebase_loader.sv
// Per-thread timebase load controller. It holds the mode/status word,
// sequences RESET -> NOT_SET -> SYNC_WAIT -> GET_TOD -> RUNNING, bounds
// each wait, and watches the spacing of step pulses once running.
// Assumes sync_pulse, tod_strobe and step_pulse are synchronous to clk.
module timebase_loader
    import tbload_pkg::*;
#(
    parameter int TB_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [REG_W-1:0] mode_wdata,
    output logic [REG_W-1:0] mode_rdata,
    input  logic             sync_pulse,
    input  logic             tod_strobe,
    input  logic [TB_W-1:0]  tod_value,
    input  logic             step_pulse,
    input  logic             step_err,
    output logic [TB_W-1:0]  tb_value
);
    tb_state_e        state_q, state_d;
    logic [CFG_W-1:0] cfg_q;
    logic [LIM_W-1:0] lim_q;
    logic             load_q, move_q, steperr_q, tmo_q;
    logic             waiting, wait_event, wait_over;
    logic             running, gap_over, load_tod;
    logic             load_req, move_req;
    logic             unused_wbits;

    assign unused_wbits = ^{mode_wdata[63:55], mode_wdata[53:52], mode_wdata[50:48],
                            mode_wdata[31:19], mode_wdata[17]};

    // Decode the qualifying conditions of the current state.
    always_comb begin
        waiting    = (state_q == ST_SYNC_WAIT) || (state_q == ST_GET_TOD);
        running    = (state_q == ST_RUNNING);
        load_tod   = (state_q == ST_GET_TOD) && tod_strobe;
        wait_event = ((state_q == ST_SYNC_WAIT) && sync_pulse) || load_tod;
        load_req   = mode_wr && mode_wdata[LOAD_BIT] && (state_q == ST_RESET) && !load_q;
        move_req   = mode_wr && mode_wdata[MOVE_BIT] && (state_q == ST_NOT_SET);
    end

    tbload_idle_limit #(.CNT_W(LIM_W)) u_wait_win (
        .clk(clk), .rst_n(rst_n), .armed_i(waiting), .event_i(wait_event),
        .limit_i(lim_q), .over_o(wait_over)
    );

    tbload_idle_limit #(.CNT_W(GAP_W)) u_step_gap (
        .clk(clk), .rst_n(rst_n), .armed_i(running), .event_i(step_pulse),
        .limit_i(cfg_q[GAP_W-1:0]), .over_o(gap_over)
    );

    tbload_counter #(.TB_W(TB_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .load_i(load_tod), .load_val_i(tod_value),
        .inc_i(running && step_pulse), .tb_o(tb_value)
    );

    // Next-state selection for the load sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:     if (load_q) state_d = ST_NOT_SET;
            ST_NOT_SET:   if (move_req) state_d = ST_SYNC_WAIT;
            ST_SYNC_WAIT: if (sync_pulse) state_d = ST_GET_TOD;
                          else if (wait_over) state_d = ST_NOT_SET;
            ST_GET_TOD:   if (tod_strobe) state_d = ST_RUNNING;
                          else if (wait_over) state_d = ST_NOT_SET;
            ST_RUNNING:   state_d = ST_RUNNING;
            default:      state_d = ST_RESET;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Configuration fields, rewritten on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            lim_q <= '0;
        end else if (mode_wr) begin
            cfg_q <= mode_wdata[CFG_W-1:0];
            lim_q <= mode_wdata[LIM_LO +: LIM_W];
        end
    end

    // Load request: set by software, dropped by hardware one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= load_req;
    end

    // Move request: set by software, dropped on RUNNING entry or on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)                      move_q <= 1'b0;
        else if (move_req)               move_q <= 1'b1;
        else if (load_tod || wait_over)  move_q <= 1'b0;
    end

    // Sticky error flags; a set event wins over a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steperr_q <= 1'b0;
            tmo_q     <= 1'b0;
        end else begin
            if (step_err || gap_over)                    steperr_q <= 1'b1;
            else if (mode_wr && mode_wdata[STEPERR_BIT]) steperr_q <= 1'b0;
            if (wait_over)                               tmo_q <= 1'b1;
            else if (mode_wr && mode_wdata[TMO_BIT])     tmo_q <= 1'b0;
        end
    end

    // Assemble the readable word.
    always_comb begin
        mode_rdata                          = '0;
        mode_rdata[CFG_W-1:0]               = cfg_q;
        mode_rdata[LOAD_BIT]                = load_q;
        mode_rdata[MOVE_BIT]                = move_q;
        mode_rdata[LIM_LO +: LIM_W]         = lim_q;
        mode_rdata[STEPERR_BIT]             = steperr_q;
        mode_rdata[TMO_BIT]                 = tmo_q;
        mode_rdata[STATE_LO +: STATE_W]     = state_q;
    end

    // R2: only the five defined encodings appear
    assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_RESET, ST_NOT_SET, ST_SYNC_WAIT, ST_GET_TOD, ST_RUNNING});
    // R3: load request lives only in RESET and resolves to NOT_SET next cycle
    assert_load_resolves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> (state_q == ST_RESET) ##1 (!load_q && state_q == ST_NOT_SET));
    // R4: move request is held throughout both waiting states
    assert_move_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> move_q);
    // R5: RUNNING is entered only from GET_TOD on a strobe, with the request dropped
    assert_run_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(state_q) != ST_RUNNING) |->
            ($past(state_q) == ST_GET_TOD && $past(tod_strobe) && !move_q));
    // R5: timebase only changes by a transfer or a step while running
    assert_tb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_tod && !(running && step_pulse)) |=> $stable(tb_value));
    // R6: a timeout lands in NOT_SET with the request cleared
    assert_timeout_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_q) |-> (state_q == ST_NOT_SET && !move_q));
    // R7: a step in RUNNING advances the timebase by one
    assert_tb_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && step_pulse) |=> (tb_value == $past(tb_value) + 1'b1));
    // R9: step error input always leaves the flag set
    assert_steperr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step_err |=> steperr_q);
endmodule

// File: tb/timebase_loader_test.sv
`timescale 1ns/1ps
module timebase_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [63:0] mode_wdata = '0;
    logic [63:0] mode_rdata;
    logic        sync_pulse = 1'b0;
    logic        tod_strobe = 1'b0;
    logic [63:0] tod_value = '0;
    logic        step_pulse = 1'b0;
    logic        step_err = 1'b0;
    logic [63:0] tb_value;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    timebase_loader #(.TB_W(64)) uut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_rdata(mode_rdata), .sync_pulse(sync_pulse), .tod_strobe(tod_strobe),
        .tod_value(tod_value), .step_pulse(step_pulse), .step_err(step_err),
        .tb_value(tb_value)
    );

    localparam logic [63:0] B_LOAD = 64'd1 << 16;
    localparam logic [63:0] B_MOVE = 64'd1 << 18;
    localparam logic [63:0] B_SERR = 64'd1 << 51;
    localparam logic [63:0] B_TMO  = 64'd1 << 54;

    typedef struct packed {
        logic [15:0] lim;
        logic [7:0]  ks;
        logic [7:0]  kt;
        logic [63:0] val;
        logic        run;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{16'd4, 8'd0, 8'd0, 64'h0123_4567_89AB_CDEF, 1'b1},
        '{16'd4, 8'd4, 8'd4, 64'hFEDC_BA98_7654_3210, 1'b1},
        '{16'd4, 8'd5, 8'd0, 64'h0000_0000_0000_1111, 1'b0},
        '{16'd4, 8'd1, 8'd5, 64'h0000_0000_0000_2222, 1'b0},
        '{16'd0, 8'd0, 8'd0, 64'h0000_0000_0000_3333, 1'b1},
        '{16'd2, 8'd3, 8'd0, 64'h0000_0000_0000_4444, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] st();
        return 64'(mode_rdata[63:60]);
    endfunction

    function automatic logic [63:0] mk(logic [7:0] gap, logic [15:0] lim);
        return (64'(lim) << 32) | 64'(gap);
    endfunction

    task automatic wr(logic [63:0] d);
        mode_wr = 1'b1;
        mode_wdata = d;
        tick();
        mode_wr = 1'b0;
        mode_wdata = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic to_not_set(logic [63:0] cfg);
        wr(cfg | B_LOAD);
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // Table walk: wait limits and event spacing
        foreach (VEC[i]) begin
            do_reset();
            to_not_set(mk(8'hFF, VEC[i].lim));
            check($sformatf("R3 vec%0d not_set", i), st(), 64'd2);
            wr(mk(8'hFF, VEC[i].lim) | B_MOVE);
            repeat (int'(VEC[i].ks)) tick();
            sync_pulse = 1'b1;
            tick();
            sync_pulse = 1'b0;
            repeat (int'(VEC[i].kt)) tick();
            tod_strobe = 1'b1;
            tod_value = VEC[i].val;
            tick();
            tod_strobe = 1'b0;
            if (VEC[i].run) begin
                check($sformatf("R5 vec%0d state", i), st(), 64'd8);
                check($sformatf("R5 vec%0d tb", i), tb_value, VEC[i].val);
                check($sformatf("R6 vec%0d no timeout", i), 64'(mode_rdata[54]), 64'd0);
            end else begin
                check($sformatf("R6 vec%0d state", i), st(), 64'd2);
                check($sformatf("R6 vec%0d tb", i), tb_value, 64'd0);
                check($sformatf("R6 vec%0d timeout", i), 64'(mode_rdata[54]), 64'd1);
            end
            check($sformatf("R5 vec%0d move clear", i), 64'(mode_rdata[18]), 64'd0);
        end

        // R1 reset state
        do_reset();
        check("R1 reset word", mode_rdata, 64'd0);
        check("R1 reset tb", tb_value, 64'd0);

        // R2 field readback, state field not writable
        wr(64'hF000_ABCD_00F0_5A5A);
        check("R2 readback", mode_rdata, 64'h0000_ABCD_0000_5A5A);

        // R4 move request ignored in RESET
        wr(B_MOVE);
        check("R4 move in reset state", st(), 64'd0);
        check("R4 move in reset bit", 64'(mode_rdata[18]), 64'd0);

        // R3 load bit visible one cycle then cleared
        wr(B_LOAD);
        check("R3 load bit set", 64'(mode_rdata[16]), 64'd1);
        check("R3 still reset", st(), 64'd0);
        tick();
        check("R3 load bit cleared", 64'(mode_rdata[16]), 64'd0);
        check("R3 reached not_set", st(), 64'd2);

        // R3 load request ignored outside RESET
        wr(B_LOAD);
        check("R3 load in not_set", 64'(mode_rdata[16]), 64'd0);

        // R4 sync ignored in NOT_SET; R5 strobe ignored in NOT_SET
        sync_pulse = 1'b1;
        tick();
        sync_pulse = 1'b0;
        check("R4 sync in not_set", st(), 64'd2);
        tod_strobe = 1'b1;
        tod_value = 64'h55;
        tick();
        tod_strobe = 1'b0;
        check("R5 strobe in not_set", tb_value, 64'd0);

        // R4 move enters SYNC_WAIT; R5 strobe before sync is ignored
        wr(mk(8'd2, 16'd1000) | B_MOVE);
        check("R4 sync_wait", st(), 64'd6);
        check("R4 move bit held", 64'(mode_rdata[18]), 64'd1);
        tod_strobe = 1'b1;
        tod_value = 64'h77;
        tick();
        tod_strobe = 1'b0;
        check("R5 strobe in sync_wait state", st(), 64'd6);
        check("R5 strobe in sync_wait tb", tb_value, 64'd0);
        sync_pulse = 1'b1;
        tick();
        sync_pulse = 1'b0;
        check("R4 get_tod", st(), 64'd7);
        tod_strobe = 1'b1;
        tod_value = 64'h0000_0010_0000_00F0;
        tick();
        tod_strobe = 1'b0;
        check("R5 running", st(), 64'd8);
        check("R5 tb loaded", tb_value, 64'h0000_0010_0000_00F0);

        // R7 steps
        step_pulse = 1'b1;
        repeat (3) tick();
        step_pulse = 1'b0;
        check("R7 three steps", tb_value, 64'h0000_0010_0000_00F3);

        // R8 step gap limit 2: two idle cycles fine, third sets the flag
        tick();
        tick();
        check("R8 gap at limit", 64'(mode_rdata[51]), 64'd0);
        check("R7 hold without step", tb_value, 64'h0000_0010_0000_00F3);
        tick();
        check("R8 gap exceeded", 64'(mode_rdata[51]), 64'd1);

        // R1 reset from RUNNING
        do_reset();
        check("R1 reset from running word", mode_rdata, 64'd0);
        check("R1 reset from running tb", tb_value, 64'd0);

        // R9 step_err sets, write-one clears, set wins over clear
        step_err = 1'b1;
        tick();
        step_err = 1'b0;
        check("R9 step_err sets", 64'(mode_rdata[51]), 64'd1);
        step_err = 1'b1;
        wr(B_SERR);
        step_err = 1'b0;
        check("R9 set beats clear", 64'(mode_rdata[51]), 64'd1);
        wr(B_SERR);
        check("R9 clear bit51", 64'(mode_rdata[51]), 64'd0);

        // R6 limit zero times out on the first idle cycle; R9 clear bit54
        to_not_set(mk(8'hFF, 16'd0));
        wr(mk(8'hFF, 16'd0) | B_MOVE);
        check("R6 entered sync_wait", st(), 64'd6);
        tick();
        check("R6 zero limit state", st(), 64'd2);
        check("R6 zero limit flag", 64'(mode_rdata[54]), 64'd1);
        check("R6 zero limit move", 64'(mode_rdata[18]), 64'd0);
        wr(B_TMO);
        check("R9 clear bit54", 64'(mode_rdata[54]), 64'd0);

        finish_run();
    end
endmodule